// File: doc/BRIEF.md
# Clocked Serial Port with Inter-Byte Gap

This block moves bytes in both directions over a synchronous serial link. One byte goes out on `sout` and one comes in on `sin` on the same serial clock, eight bits each, least significant bit first. When a start pulse arrives, the block sends a block of bytes. The length of the block comes from a byte-count register. The block fetches each outgoing byte through a request/acknowledge handshake and hands each incoming byte over on a valid/ready output.

A control register chooses where the serial clock comes from. With the internal clock, the block divides the system clock and drives the serial clock pin. It also holds the line high for a programmable number of transfer-clock periods between bytes, which gives a slow peer time to service each byte. With the external clock, the pin is an input and the block simply follows its edges, so the gap setting has no effect. Software has to pick a divider and gap code that give the peer enough system-clock cycles; the block does not check this.

Control word layout: bit 8 selects the external clock when set. Bits 7:5 are the divider code. Bits 4:0 are the gap code k. The length register holds the number of bytes minus one.

Top module: `sio_autogap`

## Requirements
- R1: With the internal clock, divider code 000, 001 or 010 gives a transfer-clock period of 4, 8 or 16 system cycles. The serial clock stays low for half of the period and high for the other half.
- R2: Any other divider code (011 to 111) gives the same period as code 010, which is 16 system cycles.
- R3: With the internal clock, the serial clock stays high between consecutive bytes for exactly (k+2) transfer-clock periods. This time runs from the rising edge of a byte's last bit to the falling edge of the next byte's first bit, provided the next byte has already been fetched.
- R4: `sout` changes only on falling serial-clock edges and presents bit 0 first. `sin` is sampled on rising edges, and the first sampled bit becomes bit 0 of the received byte.
- R5: The serial clock idles high with `sclk_oe`=1 when the internal clock is selected. No gap follows the last byte of a block.
- R6: `done` is high for exactly one cycle. That cycle is the one in which the last byte's final bit is sampled, `rx_valid` presents that byte, and `busy` has dropped.
- R7: A received byte stays on `rx_valid`/`rx_data` until `rx_ready` is high. A byte received while the previous one is still pending replaces it.
- R8: `tx_req` is high while the block still needs an outgoing byte and none is held. A byte is taken in a cycle where both `tx_req` and `tx_ack` are high, and `tx_req` is low in the cycle after that. The first byte is taken before the first falling edge of the block.
- R9: With control bit 8 set, `sclk_oe` is 0. Bits shift on the edges of `sclk_in`, and the gap code has no effect: the next byte starts on the next falling edge after the previous byte.
- R10: Writes to the control or length register while `busy` is high are discarded. Both the running block and later blocks use the old values.
- R11: A length register value of n sends and receives exactly n+1 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 9 | Control word: [8] external clock, [7:5] divider, [4:0] gap code |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 8 | Number of bytes in a block minus one |
| start | input | 1 | Starts a block when idle |
| busy | output | 1 | High while a block is running |
| done | output | 1 | One-cycle pulse at the end of a block |
| tx_req | output | 1 | Requests the next outgoing byte |
| tx_ack | input | 1 | Outgoing byte is present on tx_data |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | A received byte is pending |
| rx_ready | input | 1 | Consumer takes the pending byte |
| rx_data | output | 8 | Received byte |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| sclk_out | output | 1 | Driven serial clock |
| sclk_oe | output | 1 | High when the block drives the serial clock |
| sclk_in | input | 1 | Serial clock from outside |

## Verification
With the internal clock, every level of the serial clock changes on a system edge. Low and high phases last exactly half a period. The inter-byte high run lasts exactly (k+2) times the period, with no added latency, because the next byte is fetched while the current one is shifting. `rx_valid` and `done` rise on the same edge that raises the final serial-clock level of a block, and `busy` falls on that edge too. The bench samples every output at the falling system edge and measures each serial-clock level as a count of those samples. It compares these counts for equality, and checks `done`, `rx_valid` and `busy` in the sample where `done` is seen. With the external clock, the block's response lags by its three-flop edge detector. The bench therefore drives `sclk_in` shortly after a rising system edge and keeps each level for eight cycles, so data is checked well inside each level.

// File: rtl/sio_pkg.sv
package sio_pkg;
    // Bits in one serial word.
    localparam int DATA_W = 8;
    // Control word width: clock source, divider code, gap code.
    localparam int CTL_W  = 9;
    localparam int GAP_LSB = 0;
    localparam int GAP_W   = 5;
    localparam int DIV_LSB = 5;
    localparam int DIV_W   = 3;
    localparam int EXT_BIT = 8;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_LOW   = 3'd2,
        S_HIGH  = 3'd3,
        S_GAP   = 3'd4,
        S_XRUN  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/sio_cfg.sv
// sio_cfg: holds the control and length registers and decodes them into
// the half-period and gap lengths in system cycles.
// Assumes: busy comes from the sequencer; writes that arrive while it is
// high are dropped, so the decoded values stay put for a whole block.
module sio_cfg
    import sio_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             busy,
    output logic             ext_mode,
    output logic [TMR_W-1:0] half_cyc,
    output logic [TMR_W-1:0] gap_cyc,
    output logic [LEN_W-1:0] last_idx
);
    logic [CTL_W-1:0] ctl_q;
    logic [LEN_W-1:0] len_q;
    logic [1:0]       rate_sel;
    logic [2:0]       gap_sh;

    // Register writes, accepted only while no block is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            len_q <= '0;
        end else begin
            if (ctl_we && !busy) ctl_q <= ctl_wdata;
            if (len_we && !busy) len_q <= len_wdata;
        end
    end

    // Divider code to shift amount; unknown codes fall to the slowest rate.
    always_comb begin
        case (ctl_q[DIV_LSB +: DIV_W])
            3'b000:  rate_sel = 2'd0;
            3'b001:  rate_sel = 2'd1;
            default: rate_sel = 2'd2;
        endcase
        gap_sh   = {1'b0, rate_sel} + 3'd2;
        half_cyc = TMR_W'(2) << rate_sel;
        gap_cyc  = (TMR_W'(ctl_q[GAP_LSB +: GAP_W]) + TMR_W'(2)) << gap_sh;
    end

    assign ext_mode = ctl_q[EXT_BIT];
    assign last_idx = len_q;

    AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctl_q) && $stable(len_q))); // R10
endmodule

// File: rtl/sio_ext_edge.sv
// sio_ext_edge: brings the outside serial clock into the system clock
// domain and marks its rising and falling edges with one-cycle pulses.
// Assumes: each outside clock level lasts several system cycles.
module sio_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic ext_rise,
    output logic ext_fall
);
    logic [2:0] sync_q;

    // Two-flop synchronizer plus one flop of history, reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], sclk_in};
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];
    assign ext_fall = ~sync_q[1] & sync_q[2];
endmodule

// File: rtl/sio_shift.sv
// sio_shift: the transmit and receive shift registers. A load or shift
// pulse marks a falling serial edge; a rise pulse marks a sampling edge.
// Assumes: the pulses come from the sequencer and never overlap.
module sio_shift
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_fall,
    input  logic              sh_fall,
    input  logic              rise,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              sin,
    output logic              sout,
    output logic [DATA_W-1:0] rx_next
);
    logic [DATA_W-2:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;

    // Drive the next outgoing bit on each falling edge, bit 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sout  <= 1'b1;
            tx_sr <= '0;
        end else if (ld_fall) begin
            sout  <= ld_data[0];
            tx_sr <= ld_data[DATA_W-1:1];
        end else if (sh_fall) begin
            sout  <= tx_sr[0];
            tx_sr <= {1'b0, tx_sr[DATA_W-2:1]};
        end
    end

    // Shift the sampled input bit in from the top on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_sr <= '0;
        else if (rise) rx_sr <= rx_next;
    end

    assign rx_next = {sin, rx_sr[DATA_W-1:1]};

    AST_SOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_fall && !sh_fall) |=> $stable(sout)); // R4
endmodule

// File: rtl/sio_seq.sv
// sio_seq: the block sequencer. It fetches outgoing bytes, produces the
// internal serial clock with its low, high and gap phases, follows outside
// edges in external mode, and presents received bytes and the end pulse.
// Assumes: configuration inputs stay constant while busy is high.
module sio_seq
    import sio_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_mode,
    input  logic [TMR_W-1:0]  half_cyc,
    input  logic [TMR_W-1:0]  gap_cyc,
    input  logic [LEN_W-1:0]  last_idx,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              tx_ack,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] rx_next,
    output logic              busy,
    output logic              sclk_q,
    output logic              ld_fall,
    output logic              sh_fall,
    output logic              rise,
    output logic              tx_req,
    output logic [DATA_W-1:0] hold_q,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int REM_W = LEN_W + 1;

    seq_state_t       state;
    logic [TMR_W-1:0] tmr;
    logic [BIT_W-1:0] bitn;
    logic [REM_W-1:0] rem;
    logic             hold_vld;
    logic             phase_end;
    logic             gap_end;
    logic             last_bit;
    logic             blk_end;

    // Edge decisions for the current cycle.
    always_comb begin
        phase_end = (tmr == half_cyc - TMR_W'(1));
        gap_end   = (tmr >= gap_cyc - TMR_W'(1));
        ld_fall   = 1'b0;
        sh_fall   = 1'b0;
        rise      = 1'b0;
        case (state)
            S_FETCH: ld_fall = hold_vld;
            S_LOW:   rise    = phase_end;
            S_HIGH:  sh_fall = phase_end;
            S_GAP:   ld_fall = gap_end && hold_vld;
            S_XRUN: begin
                rise    = ext_rise;
                ld_fall = ext_fall && (bitn == '0);
                sh_fall = ext_fall && (bitn != '0);
            end
            default: ;
        endcase
        last_bit = rise && (bitn == BIT_W'(DATA_W - 1));
        blk_end  = last_bit && (rem == '0);
    end

    assign busy   = (state != S_IDLE);
    assign tx_req = busy && (rem != '0) && !hold_vld;

    // State, phase timer, bit and byte counters, serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            tmr    <= '0;
            bitn   <= '0;
            rem    <= '0;
            sclk_q <= 1'b1;
        end else begin
            if (ld_fall) rem <= rem - REM_W'(1);
            if (rise)    bitn <= bitn + BIT_W'(1);
            case (state)
                S_IDLE: begin
                    sclk_q <= 1'b1;
                    if (start) begin
                        rem   <= REM_W'(last_idx) + REM_W'(1);
                        bitn  <= '0;
                        tmr   <= '0;
                        state <= ext_mode ? S_XRUN : S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (ld_fall) begin
                        sclk_q <= 1'b0;
                        tmr    <= '0;
                        state  <= S_LOW;
                    end
                end
                S_LOW: begin
                    if (rise) begin
                        sclk_q <= 1'b1;
                        tmr    <= '0;
                        if (!last_bit)    state <= S_HIGH;
                        else if (blk_end) state <= S_IDLE;
                        else              state <= S_GAP;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                S_HIGH: begin
                    if (sh_fall) begin
                        sclk_q <= 1'b0;
                        tmr    <= '0;
                        state  <= S_LOW;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                S_GAP: begin
                    if (ld_fall) begin
                        sclk_q <= 1'b0;
                        tmr    <= '0;
                        state  <= S_LOW;
                    end else if (!gap_end) begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                S_XRUN: begin
                    if (blk_end) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Holding register for the next outgoing byte; a new fetch wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else begin
            if (ld_fall) hold_vld <= 1'b0;
            if (tx_req && tx_ack) begin
                hold_vld <= 1'b1;
                hold_q   <= tx_data;
            end
        end
    end

    // Received-byte output and the end-of-block pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            done     <= 1'b0;
        end else begin
            done <= blk_end;
            if (last_bit) begin
                rx_valid <= 1'b1;
                rx_data  <= rx_next;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> sclk_q); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_LOW_HALF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_q) && !ext_mode) |-> ($past(tmr) == half_cyc - TMR_W'(1))); // R1
    AST_GAP_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk_q) && $past(state) == S_GAP) |-> ($past(tmr) >= gap_cyc - TMR_W'(1))); // R3
    AST_REQ_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_ack) |=> !tx_req); // R8
endmodule

// File: rtl/sio_autogap.sv
// sio_autogap: synchronous serial transmit/receive port with a programmable
// idle gap between bytes of a block. It ties the register bank, the
// external-edge detector, the sequencer and the shift registers together.
// Assumes: sclk_in is used only when the control word selects it.
module sio_autogap
    import sio_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              tx_req,
    input  logic              tx_ack,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              sout,
    input  logic              sin,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sclk_in
);
    logic              ext_mode;
    logic [TMR_W-1:0]  half_cyc;
    logic [TMR_W-1:0]  gap_cyc;
    logic [LEN_W-1:0]  last_idx;
    logic              ext_rise;
    logic              ext_fall;
    logic              ld_fall;
    logic              sh_fall;
    logic              rise;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rx_next;
    logic              sclk_q;

    sio_cfg #(.LEN_W(LEN_W), .TMR_W(TMR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .len_we(len_we), .len_wdata(len_wdata),
        .busy(busy),
        .ext_mode(ext_mode), .half_cyc(half_cyc),
        .gap_cyc(gap_cyc), .last_idx(last_idx)
    );

    sio_ext_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
        .ext_rise(ext_rise), .ext_fall(ext_fall)
    );

    sio_seq #(.LEN_W(LEN_W), .TMR_W(TMR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ext_mode(ext_mode), .half_cyc(half_cyc),
        .gap_cyc(gap_cyc), .last_idx(last_idx),
        .ext_rise(ext_rise), .ext_fall(ext_fall),
        .tx_ack(tx_ack), .tx_data(tx_data),
        .rx_ready(rx_ready), .rx_next(rx_next),
        .busy(busy), .sclk_q(sclk_q),
        .ld_fall(ld_fall), .sh_fall(sh_fall), .rise(rise),
        .tx_req(tx_req), .hold_q(hold_q),
        .rx_valid(rx_valid), .rx_data(rx_data), .done(done)
    );

    sio_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .ld_fall(ld_fall), .sh_fall(sh_fall), .rise(rise),
        .ld_data(hold_q), .sin(sin),
        .sout(sout), .rx_next(rx_next)
    );

    assign sclk_out = sclk_q;
    assign sclk_oe  = !ext_mode;
endmodule

// File: tb/tb_sio_autogap.sv
`timescale 1ns/1ps
module tb_sio_autogap;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic       len_we = 1'b0;
    logic [7:0] len_wdata = '0;
    logic       start = 1'b0;
    logic       busy, done, tx_req, rx_valid, sout, sclk_out, sclk_oe;
    logic       tx_ack = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_ready = 1'b1;
    logic [7:0] rx_data;
    logic       sin = 1'b1;
    logic       sclk_in = 1'b1;

    sio_autogap dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .len_we(len_we), .len_wdata(len_wdata), .start(start),
        .busy(busy), .done(done), .tx_req(tx_req), .tx_ack(tx_ack),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .sout(sout), .sin(sin), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sclk_in(sclk_in)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] tx_src[$];
    logic [7:0] exp_sout[$];
    logic [7:0] slave_src[$];
    logic [7:0] exp_rx[$];

    int  exp_half = 2;
    int  exp_gap  = 8;
    bit  tim_on   = 0;
    bit  mon_en   = 1;
    bit  first_fall = 1;
    int  bitpos   = 0;
    int  run      = 0;
    int  done_cnt = 0;
    logic       prev_sck  = 1'b1;
    logic       prev_sout = 1'b1;
    logic       prev_done = 1'b0;
    logic       sck;
    logic [7:0] cur_r = '0;
    logic [7:0] got_tx = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: queue one outgoing and one incoming byte with their expectations.
    task automatic push_pair(input logic [7:0] t, input logic [7:0] r);
        tx_src.push_back(t);
        exp_sout.push_back(t);
        slave_src.push_back(r);
        exp_rx.push_back(r);
    endtask

    task automatic write_ctl(input logic [8:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic write_len(input logic [7:0] v);
        @(negedge clk); len_we = 1'b1; len_wdata = v;
        @(negedge clk); len_we = 1'b0;
    endtask

    // Bench's own model of the timing for a control word.
    task automatic set_mode(input logic ext, input logic [2:0] div, input logic [4:0] k);
        case (div)
            3'b000:  exp_half = 2;
            3'b001:  exp_half = 4;
            default: exp_half = 8;
        endcase
        exp_gap = (int'(k) + 2) * 2 * exp_half;
        tim_on  = !ext;
        write_ctl({ext, div, k});
    endtask

    task automatic run_block(input int nbytes, input bit ext);
        int t;
        done_cnt = 0;
        first_fall = 1;
        bitpos = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (ext) begin
            repeat (6) @(negedge clk);
            for (int b = 0; b < nbytes * 8; b++) begin
                @(posedge clk); #1 sclk_in = 1'b0;
                repeat (8) @(posedge clk);
                #1 sclk_in = 1'b1;
                repeat (7) @(posedge clk);
            end
        end
        t = 0;
        while (busy && t < 40000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(!busy, "R6", "block finished", busy, 0);
        check(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
        check(exp_sout.size() == 0, "R11", "outgoing bytes left", exp_sout.size(), 0);
        check(sclk_out == 1'b1, "R5", "serial clock idle level", sclk_out, 1);
    endtask

    // Byte source: acknowledge each request with the next queued byte.
    always @(negedge clk) begin
        if (tx_req && tx_src.size() > 0) begin
            tx_ack  = 1'b1;
            tx_data = tx_src.pop_front();
        end else begin
            tx_ack = 1'b0;
        end
    end

    // Serial peer and timing monitor: drive sin on falls, take sout on rises.
    always @(negedge clk) begin
        if (rst_n) begin
            sck = sclk_oe ? sclk_out : sclk_in;
            if (tim_on && sout !== prev_sout)
                check(prev_sck && !sck, "R4", "sout moved off a falling edge", sout, prev_sout);
            if (sck !== prev_sck) begin
                if (!sck) begin
                    if (tim_on && !first_fall) begin
                        if (bitpos == 0) check(run == exp_gap, "R3", "inter-byte gap cycles", run, exp_gap);
                        else             check(run == exp_half, "R1", "high phase cycles", run, exp_half);
                    end
                    first_fall = 0;
                    if (bitpos == 0) cur_r = (slave_src.size() > 0) ? slave_src.pop_front() : 8'h00;
                    sin = cur_r[bitpos];
                end else begin
                    if (tim_on) check(run == exp_half, "R1", "low phase cycles", run, exp_half);
                    got_tx[bitpos] = sout;
                    bitpos++;
                    if (bitpos == 8) begin
                        logic [7:0] e;
                        bitpos = 0;
                        e = (exp_sout.size() > 0) ? exp_sout.pop_front() : 8'hxx;
                        check(got_tx === e, "R4", "byte seen on sout", got_tx, e);
                    end
                end
                run = 1;
            end else begin
                run++;
            end
            prev_sck  = sck;
            prev_sout = sout;
        end
    end

    // Scoreboard monitor for received bytes and the end pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_en && rx_valid && rx_ready) begin
                logic [7:0] e;
                e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'hxx;
                check(rx_data === e, "R4", "received byte", rx_data, e);
            end
            if (done) begin
                done_cnt++;
                check(!prev_done, "R6", "done width", prev_done, 0);
                check(rx_valid && !busy, "R6", "rx_valid/busy at done", {rx_valid, busy}, 2);
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk_out == 1'b1 && sclk_oe == 1'b1, "R5", "reset clock pin", {sclk_out, sclk_oe}, 3);
        check(!busy && !done && !rx_valid, "R6", "reset status", {busy, done, rx_valid}, 0);
        check(!tx_req, "R8", "no request at reset", tx_req, 0);

        // R1/R3: divide by 4, gap code 0, three bytes.
        set_mode(1'b0, 3'b000, 5'd0);
        write_len(8'd2);
        push_pair(8'hA5, 8'h5A); push_pair(8'h3C, 8'hC3); push_pair(8'hF0, 8'h0F);
        run_block(3, 0);

        // R1/R3: divide by 8, gap code 3, two bytes.
        set_mode(1'b0, 3'b001, 5'd3);
        write_len(8'd1);
        push_pair(8'h81, 8'h7E); push_pair(8'h12, 8'hED);
        run_block(2, 0);

        // R1/R5/R11: divide by 16, gap code 5, single byte.
        set_mode(1'b0, 3'b010, 5'd5);
        write_len(8'd0);
        push_pair(8'h6B, 8'h94);
        run_block(1, 0);

        // R2: unused divider code behaves as divide by 16.
        set_mode(1'b0, 3'b101, 5'd1);
        write_len(8'd1);
        push_pair(8'h01, 8'h80); push_pair(8'hFE, 8'h7F);
        run_block(2, 0);

        // R10: writes during a block are dropped, now and afterwards.
        set_mode(1'b0, 3'b000, 5'd2);
        write_len(8'd1);
        push_pair(8'h55, 8'hAA); push_pair(8'hC0, 8'h03);
        fork
            run_block(2, 0);
            begin
                repeat (10) @(negedge clk);
                ctl_we = 1'b1; len_we = 1'b1;
                ctl_wdata = 9'b0_010_00101; len_wdata = 8'd5;
                @(negedge clk);
                ctl_we = 1'b0; len_we = 1'b0;
            end
        join
        push_pair(8'h99, 8'h66); push_pair(8'h24, 8'h42);
        run_block(2, 0);
        check(exp_rx.size() == 0, "R10", "old length kept", exp_rx.size(), 0);

        // R7: pending byte held while not ready, then replaced by the next.
        mon_en = 0;
        rx_ready = 1'b0;
        set_mode(1'b0, 3'b000, 5'd0);
        write_len(8'd1);
        push_pair(8'h11, 8'h3A); push_pair(8'h22, 8'hB7);
        run_block(2, 0);
        check(rx_valid == 1'b1, "R7", "byte held while not ready", rx_valid, 1);
        check(rx_data == 8'hB7, "R7", "newer byte replaces older", rx_data, 8'hB7);
        exp_rx.delete();
        rx_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(rx_valid == 1'b0, "R7", "taken when ready", rx_valid, 0);
        mon_en = 1;

        // R9: outside clock, large gap code ignored, back-to-back bytes.
        set_mode(1'b1, 3'b000, 5'd31);
        write_len(8'd2);
        @(negedge clk);
        check(sclk_oe == 1'b0, "R9", "pin released in external mode", sclk_oe, 0);
        push_pair(8'hD2, 8'h2D); push_pair(8'h47, 8'h74); push_pair(8'hE8, 8'h8E);
        run_block(3, 1);
        check(exp_rx.size() == 0, "R9", "all bytes received", exp_rx.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule